// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides two 32-bit integers, signed or unsigned, inside a single execute stage of an in-order pipeline. A one-cycle start pulse captures both operands and the mode. The block then holds the stage with a busy signal while it works out the quotient and remainder one bit per cycle with a restoring shift-and-subtract loop.

It does not always run a fixed 32 steps. A setup cycle takes the magnitude of the dividend and counts its leading zeros. Only the significant bits are then iterated. A final cycle applies the signs. Small dividends therefore leave the stage early. The busy time is the number of significant dividend bits plus two, and at most 34 cycles. The results appear with a one-cycle done pulse and stay on the outputs until the next result replaces them.

Top module: `earlyExitDivider`

## Requirements
- R1: While reset is held and right after it, busy and done are 0 and quotient and remainder are 0.
- R2: A start seen while busy is 0 captures dividend, divisor and isSigned, and busy is 1 in the next cycle.
- R3: Busy stays high for exactly (32 − number of leading zeros of the dividend magnitude) + 2 cycles. In signed mode the magnitude is the absolute value; in unsigned mode it is the raw dividend. The maximum is 34 cycles.
- R4: Done is a one-cycle pulse in the cycle right after busy falls. Quotient and remainder take their new values in that same cycle and keep them until the next done.
- R5: With isSigned = 0, quotient = dividend / divisor and remainder = dividend mod divisor, both taken as unsigned numbers.
- R6: With isSigned = 1, the operands are two's complement and the quotient is truncated toward zero. The quotient is negative when the operand signs differ, and the remainder has the dividend's sign.
- R7: A divisor of 0 gives quotient all ones and remainder equal to the captured dividend, with busy high for 2 cycles.
- R8: A dividend of 0 with a nonzero divisor gives quotient 0 and remainder 0, with busy high for 2 cycles.
- R9: A start while busy is 1 is ignored. The running division completes with its own operands and no second done follows.
- R10: Signed 0x80000000 divided by 0xFFFFFFFF (−1) wraps to quotient 0x80000000 with remainder 0, after 34 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; honoured only when not busy |
| isSigned | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at start |
| divisor | input | 32 | Divisor, sampled at start |
| busy | output | 1 | High while the division holds the stage |
| done | output | 1 | One-cycle pulse when a new result is on the outputs |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
Some properties are checked on every cycle. Busy rises after an accepted start. Done comes only as a single pulse right after busy falls. The outputs hold still outside done. Every busy window lies between 2 and 34 cycles, and a zero divisor or zero dividend finishes in the 2-cycle minimum. A zero divisor returns the all-ones and dividend pattern. The arithmetic values themselves can only be shown by the bench's scenarios. So can the exact busy length for each dividend width and the effect of each sign combination. Two more cases also depend on the scenarios: the wrap of the most negative value by −1, and a start that arrives mid-division.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FINAL = 2'd3
  } divState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadOps;  // capture operands and mode
    logic setup;    // magnitudes and leading-zero alignment
    logic step;     // one restoring iteration
    logic finish;   // sign fix and result register update
  } divCtrl_t;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrl,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [CW-1:0]    sigBits,
  output logic             divZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic [WIDTH-1:0] opA, opB;
  logic             modeSigned;
  logic [WIDTH-1:0] remR, workQ;
  logic             negA, negB, negQ;
  logic [WIDTH-1:0] magA, magB;
  logic [CW-1:0]    lzA;
  logic [WIDTH:0]   shifted, divExt;
  logic             geq;
  logic [WIDTH-1:0] remNext;

  function automatic logic [CW-1:0] countLz(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  always_comb begin
    negA    = modeSigned & opA[WIDTH-1];
    negB    = modeSigned & opB[WIDTH-1];
    negQ    = negA ^ negB;
    magA    = negA ? -opA : opA;
    magB    = negB ? -opB : opB;
    lzA     = countLz(magA);
    sigBits = CW'(WIDTH) - lzA;
    divZero = (opB == '0);
    shifted = {remR, workQ[WIDTH-1]};
    divExt  = {1'b0, magB};
    geq     = (shifted >= divExt);
    remNext = geq ? WIDTH'(shifted - divExt) : shifted[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA        <= '0;
      opB        <= '0;
      modeSigned <= 1'b0;
      remR       <= '0;
      workQ      <= '0;
      quotient   <= '0;
      remainder  <= '0;
    end else begin
      if (ctrl.loadOps) begin
        opA        <= dividend;
        opB        <= divisor;
        modeSigned <= isSigned;
      end
      if (ctrl.setup) begin
        remR  <= '0;
        workQ <= magA << lzA;
      end
      if (ctrl.step) begin
        remR  <= remNext;
        workQ <= {workQ[WIDTH-2:0], geq};
      end
      if (ctrl.finish) begin
        if (divZero) begin
          quotient  <= '1;
          remainder <= opA;
        end else begin
          quotient  <= negQ ? -workQ : workQ;
          remainder <= negA ? -remR : remR;
        end
      end
    end
  end
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] sigBits,
  input  logic          divZero,
  output divCtrl_t      ctrl,
  output logic          busy,
  output logic          done
);
  divState_t state;
  logic [CW-1:0] stepsLeft;

  always_comb begin
    ctrl.loadOps = start && (state == ST_IDLE);
    ctrl.setup   = (state == ST_SETUP);
    ctrl.step    = (state == ST_ITER);
    ctrl.finish  = (state == ST_FINAL);
    busy         = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= (state == ST_FINAL);
      case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          if (divZero || sigBits == '0) begin
            state <= ST_FINAL;
          end else begin
            stepsLeft <= sigBits;
            state     <= ST_ITER;
          end
        end
        ST_ITER: begin
          stepsLeft <= stepsLeft - 1'b1;
          if (stepsLeft == CW'(1)) state <= ST_FINAL;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/earlyExitDivider.sv
module earlyExitDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int CW = $clog2(WIDTH + 1);

  divCtrl_t      ctrl;
  logic [CW-1:0] sigBits;
  logic          divZero;

  divControl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .sigBits(sigBits),
    .divZero(divZero), .ctrl(ctrl), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .sigBits(sigBits),
    .divZero(divZero), .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/earlyExitDividerChecker.sv
module earlyExitDividerChecker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  localparam int LW = $clog2(WIDTH + 3) + 1;

  logic [LW-1:0]    busyLen;
  logic [WIDTH-1:0] capA, capB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= '0;
      capA    <= '0;
      capB    <= '1;
    end else if (start && !busy) begin
      busyLen <= '0;
      capA    <= dividend;
      capB    <= divisor;
    end else if (busy) begin
      busyLen <= busyLen + 1'b1;
    end
  end

  p_busy_follows_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_len_bounds_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyLen >= LW'(2) && busyLen <= LW'(WIDTH + 2)));

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder)));

  p_zero_div_fast_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && capB == '0) |-> (busyLen == LW'(2) && quotient == '1 && remainder == capA));

  p_zero_dividend_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && capA == '0) |-> busyLen == LW'(2));
endmodule

bind earlyExitDivider earlyExitDividerChecker #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
  .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
);

// File: tb/tb_earlyExitDivider.sv
module tb_earlyExitDivider;
  localparam int W = 32;
  localparam int NV = 11;
  // {isSigned, dividend, divisor}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 32'd100,        32'd7},
    {1'b0, 32'hFFFFFFFF,   32'd3},
    {1'b0, 32'h80000000,   32'h10},
    {1'b0, 32'd5,          32'd9},
    {1'b0, 32'd1,          32'd1},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {1'b1, 32'hFFFFFF9C,   32'd7},
    {1'b1, 32'd100,        32'hFFFFFFF9},
    {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9},
    {1'b1, 32'hFFFFFFFF,   32'd1},
    {1'b1, 32'h7FFFFFFF,   32'h12345}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic isSigned = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [W-1:0] quotient, remainder;
  int nChecks = 0, nFails = 0;
  int lastLen;
  logic sawDone;

  always #2.5 clk = ~clk;

  earlyExitDivider #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expLen(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] m;
    int bits;
    m = (s && a[W-1]) ? -a : a;
    bits = 0;
    for (int i = 0; i < W; i++) if (m[i]) bits = i + 1;
    return (b == '0) ? 2 : bits + 2;
  endfunction

  // Launch one division; optionally poke a second start mid-run.
  task automatic runDiv(input logic s, input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    @(negedge clk);
    start = 1'b1; isSigned = s; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    lastLen = 0;
    sawDone = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (!busy) break;
      lastLen++;
      if (poke && lastLen == 2) begin
        start = 1'b1; isSigned = 1'b0; dividend = 32'd9; divisor = 32'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    sawDone = done;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "quotient in reset", quotient, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "remainder after reset", remainder, 0);

    // R2: busy rises one cycle after start
    @(negedge clk);
    start = 1'b1; isSigned = 1'b0; dividend = 32'd50; divisor = 32'd5;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);

    // Table walk: R3 length, R4 done, R5 unsigned, R6 signed
    for (int v = 0; v < NV; v++) begin
      logic s;
      logic [W-1:0] a, b, eq, er;
      s = VEC[v][2*W]; a = VEC[v][2*W-1:W]; b = VEC[v][W-1:0];
      if (s) begin
        eq = W'($signed(a) / $signed(b));
        er = W'($signed(a) % $signed(b));
      end else begin
        eq = a / b;
        er = a % b;
      end
      runDiv(s, a, b, 1'b0);
      check("R3", "busy length", lastLen, expLen(s, a, b));
      check("R4", "done after busy", sawDone, 1);
      check(s ? "R6" : "R5", "quotient", quotient, eq);
      check(s ? "R6" : "R5", "remainder", remainder, er);
      @(negedge clk);
      check("R4", "done single pulse", done, 0);
      check("R4", "quotient held", quotient, eq);
    end

    // R3 worst case 34 cycles
    runDiv(1'b0, 32'hC0000000, 32'd2, 1'b0);
    check("R3", "worst-case length", lastLen, 34);
    check("R5", "worst-case quotient", quotient, 32'h60000000);

    // R7 divide by zero
    runDiv(1'b1, 32'hFFFFFFFB, 32'd0, 1'b0);
    check("R7", "div0 length", lastLen, 2);
    check("R7", "div0 quotient", quotient, 32'hFFFFFFFF);
    check("R7", "div0 remainder", remainder, 32'hFFFFFFFB);

    // R8 zero dividend
    runDiv(1'b1, 32'd0, 32'd13, 1'b0);
    check("R8", "zero-dividend length", lastLen, 2);
    check("R8", "zero-dividend quotient", quotient, 0);
    check("R8", "zero-dividend remainder", remainder, 0);

    // R10 most negative by -1
    runDiv(1'b1, 32'h80000000, 32'hFFFFFFFF, 1'b0);
    check("R10", "wrap length", lastLen, 34);
    check("R10", "wrap quotient", quotient, 32'h80000000);
    check("R10", "wrap remainder", remainder, 0);

    // R9 start while busy ignored
    runDiv(1'b0, 32'd1000, 32'd3, 1'b1);
    check("R9", "length unaffected", lastLen, expLen(1'b0, 32'd1000, 32'd3));
    check("R9", "quotient unaffected", quotient, 333);
    check("R9", "remainder unaffected", remainder, 1);
    @(negedge clk);
    check("R9", "no second run", busy, 0);
    @(negedge clk);
    check("R9", "no second done", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule